// File: doc/BRIEF.md
# Transport Stream Parallel Output Formatter

This block sits between an upstream packet decoder and the parallel output pins. It takes 188-byte transport packets as a byte stream and sends each one as an unbroken burst on an 8-bit bus. A packet-start strobe, a valid strobe and an active-low packet error flag go with each burst. Input bytes arrive with a start marker, a valid qualifier and an uncorrectable flag. That flag may be raised on any byte of a packet. The block writes each packet into one of two packet-sized buffers that are used in turn. It starts sending a packet only once every byte is stored and the error state for the whole packet is known.

A polarity input picks which clock edge launches the outputs. When it is 1, the outputs move on the falling edge and are settled at the rising edge. When it is 0, they move on the rising edge. An active-low enable forces the pins to their idle levels. Packets are released only while the upstream lock indication is high. A packet that arrives while both buffers are occupied is dropped, and a sticky flag records the drop.

Top module: `ts_par_out`

## Requirements
- R1: During and after reset, `ts_data` is 0, `ts_sop` and `ts_val` are 0, `ts_err_n` is 1 and `ovf_flag` is 0.
- R2: A stored packet leaves as `PKT_LEN` (188) bytes on consecutive cycles, in arrival order, with `ts_val` high for all of them. `ts_sop` is high only on the first byte, and no burst is longer than `PKT_LEN`.
- R3: Whenever `ts_val` is low, `ts_data` is all zeros and `ts_sop` is low.
- R4: `ts_err_n` is low for every byte of a packet in which `in_uncorr` was high on at least one byte, whatever that byte's position. Otherwise it is high. It does not change within a burst.
- R5: At least one cycle with `ts_val` low separates two bursts. When the next packet is already stored, the gap is exactly one cycle.
- R6: Take `clk_pol` = 0, `oe_n` = 0, `lock` = 1 and both buffers empty. `ts_sop` is then high after the second rising edge that follows the rising edge accepting a packet's final byte, and low after the first.
- R7: With `clk_pol` = 1, outputs change only at falling edges of `clk`. With `clk_pol` = 0, they change only at rising edges.
- R8: While `oe_n` is 1, the outputs hold the idle levels of R1 (`ovf_flag` excepted), starting one cycle after it is sampled high. Packets that drain during that time are not shown later.
- R9: While `lock` is 0, no burst starts and stored packets are held. They are sent once `lock` goes to 1.
- R10: Two packets can be stored. A start marker that arrives while both buffers hold packets drops that whole packet and sets `ovf_flag`, which stays set until reset.
- R11: A packet whose next start marker arrives before its `PKT_LEN`-th byte is discarded, including its error state. Collection restarts at the new marker.
- R12: Bytes with `in_valid` low, bytes that arrive before any start marker, and bytes after a complete packet that come before the next start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Upstream lock; bursts start only while high |
| clk_pol | input | 1 | 1: outputs launched on falling edge; 0: on rising edge |
| oe_n | input | 1 | Active-low output enable |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte qualifier |
| in_sop | input | 1 | Marks the first byte of an input packet |
| in_uncorr | input | 1 | Byte belongs to a packet with uncorrectable content |
| ts_data | output | 8 | Output byte bus |
| ts_sop | output | 1 | First-byte strobe |
| ts_val | output | 1 | Burst valid strobe |
| ts_err_n | output | 1 | Active-low packet error flag |
| ovf_flag | output | 1 | Sticky drop indication |

## Verification
With the rising-edge launch, the first byte reaches the pins two rising edges after the edge that stores a packet's last byte. The bench counts those two edges explicitly after the final input byte, and it checks that the start strobe is still low after the first edge. The falling-edge launch adds half a cycle. The bench samples every output two time units after a rising edge, a point that is clear of both possible launch edges. To find which edge moves the bus, the bench probes it on either side of a falling edge and of a rising edge. The enable and lock effects are due one cycle after the input is sampled, so they are checked over long windows that begin several cycles after the change.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

  // Per-beat control flags travelling with a data byte
  typedef struct packed {
    logic sop;
    logic val;
    logic err_n;
  } ts_ctl_t;

  localparam ts_ctl_t CTL_IDLE = '{sop: 1'b0, val: 1'b0, err_n: 1'b1};

  typedef enum logic [1:0] {
    EM_IDLE  = 2'd0,
    EM_BURST = 2'd1,
    EM_GAP   = 2'd2
  } em_state_t;

  // True when a byte index is the final index of a packet
  function automatic logic at_last(input int unsigned idx, input int unsigned len);
    return idx == len - 1;
  endfunction

  // Control flags for an emitted beat: errored packets pull err_n low
  function automatic ts_ctl_t beat_ctl(input logic active, input logic first,
                                       input logic bad);
    ts_ctl_t c;
    c.val   = active;
    c.sop   = active & first;
    c.err_n = ~(active & bad);
    return c;
  endfunction

endpackage

// File: rtl/ts_collect.sv
module ts_collect
  import ts_fmt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PKT_LEN = 188,
  parameter int IW      = $clog2(PKT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_uncorr,
  input  logic [1:0]    full,
  output logic          wr_en,
  output logic          wr_buf,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          pkt_done,
  output logic          pkt_err,
  output logic          drop_evt,
  output logic          ovf
);

  logic          busy;
  logic [IW-1:0] idx;
  logic          err_acc;
  logic          wbuf;
  logic          sop_hit;

  assign sop_hit  = in_valid & in_sop;
  // wbuf is the buffer after the newest stored one: full there means both full
  assign drop_evt = sop_hit & full[wbuf];
  assign wr_en    = in_valid & (in_sop ? ~full[wbuf] : busy);
  assign wr_idx   = in_sop ? '0 : idx;
  assign wr_buf   = wbuf;
  assign wr_data  = in_data;
  assign pkt_done = in_valid & ~in_sop & busy & at_last(32'(idx), PKT_LEN);
  assign pkt_err  = err_acc | in_uncorr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      err_acc <= 1'b0;
      wbuf    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (drop_evt) ovf <= 1'b1;
      if (sop_hit) begin
        busy    <= ~full[wbuf];
        idx     <= IW'(1);
        err_acc <= in_uncorr;
      end else if (in_valid && busy) begin
        if (pkt_done) begin
          busy <= 1'b0;
          idx  <= '0;
          wbuf <= ~wbuf;
        end else begin
          idx     <= idx + 1'b1;
          err_acc <= err_acc | in_uncorr;
        end
      end
    end
  end

endmodule

// File: rtl/ts_pp_store.sv
module ts_pp_store #(
  parameter int DW      = 8,
  parameter int PKT_LEN = 188,
  parameter int IW      = $clog2(PKT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_buf,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          set_full,
  input  logic          set_err,
  input  logic          rd_buf,
  input  logic [IW-1:0] rd_idx,
  input  logic          rd_clr,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    full,
  output logic [1:0]    err
);

  logic [DW-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [PKT_LEN];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_buf == 1'(b))) mem[wr_idx] <= wr_data;
    end
    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_data = bank_rd[rd_buf];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      err  <= '0;
    end else begin
      if (set_full) begin
        full[wr_buf] <= 1'b1;
        err[wr_buf]  <= set_err;
      end
      if (rd_clr) full[rd_buf] <= 1'b0;
    end
  end

endmodule

// File: rtl/ts_emit.sv
module ts_emit
  import ts_fmt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PKT_LEN = 188,
  parameter int IW      = $clog2(PKT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic [1:0]    full,
  input  logic [1:0]    err,
  input  logic [DW-1:0] rd_data,
  output logic          rd_buf,
  output logic [IW-1:0] rd_idx,
  output logic          rd_clr,
  output logic          seq_start,
  output logic [DW-1:0] emit_data,
  output ts_ctl_t       emit_ctl
);

  em_state_t st;
  logic      in_burst;

  assign in_burst  = (st == EM_BURST);
  assign rd_clr    = in_burst & at_last(32'(rd_idx), PKT_LEN);
  assign seq_start = ~in_burst & lock & full[rd_buf];
  assign emit_ctl  = beat_ctl(in_burst, rd_idx == '0, err[rd_buf]);
  assign emit_data = in_burst ? rd_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EM_IDLE;
      rd_idx <= '0;
      rd_buf <= 1'b0;
    end else begin
      case (st)
        EM_BURST: begin
          if (rd_clr) begin
            st     <= EM_GAP;
            rd_idx <= '0;
            rd_buf <= ~rd_buf;
          end else begin
            rd_idx <= rd_idx + 1'b1;
          end
        end
        default: begin
          st     <= seq_start ? EM_BURST : EM_IDLE;
          rd_idx <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ts_launch.sv
module ts_launch
  import ts_fmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_pol,
  input  logic          oe_n,
  input  logic [DW-1:0] emit_data,
  input  ts_ctl_t       emit_ctl,
  output logic [DW-1:0] out_data,
  output ts_ctl_t       out_ctl
);

  logic [DW-1:0] rise_d, fall_d;
  ts_ctl_t       rise_c, fall_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= '0;
      rise_c <= CTL_IDLE;
    end else if (oe_n) begin
      rise_d <= '0;
      rise_c <= CTL_IDLE;
    end else begin
      rise_d <= emit_data;
      rise_c <= emit_ctl;
    end
  end

  // Half-cycle retiming stage for falling-edge launch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_d <= '0;
      fall_c <= CTL_IDLE;
    end else begin
      fall_d <= rise_d;
      fall_c <= rise_c;
    end
  end

  assign out_data = clk_pol ? fall_d : rise_d;
  assign out_ctl  = clk_pol ? fall_c : rise_c;

endmodule

// File: rtl/ts_par_out.sv
module ts_par_out
  import ts_fmt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PKT_LEN = 188
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          clk_pol,
  input  logic          oe_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_uncorr,
  output logic [DW-1:0] ts_data,
  output logic          ts_sop,
  output logic          ts_val,
  output logic          ts_err_n,
  output logic          ovf_flag
);

  localparam int IW = $clog2(PKT_LEN);

  // Named internal events
  logic          wr_en, wr_buf, pkt_done, pkt_err, drop_evt;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] wr_data, rd_data, emit_data;
  logic [1:0]    full, err;
  logic          rd_buf, rd_clr, seq_start;
  ts_ctl_t       emit_ctl, out_ctl;

  ts_collect #(.DW(DW), .PKT_LEN(PKT_LEN), .IW(IW)) u_collect (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_sop(in_sop), .in_uncorr(in_uncorr), .full(full),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_data(wr_data),
    .pkt_done(pkt_done), .pkt_err(pkt_err), .drop_evt(drop_evt), .ovf(ovf_flag)
  );

  ts_pp_store #(.DW(DW), .PKT_LEN(PKT_LEN), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx),
    .wr_data(wr_data), .set_full(pkt_done), .set_err(pkt_err),
    .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_clr(rd_clr), .rd_data(rd_data),
    .full(full), .err(err)
  );

  ts_emit #(.DW(DW), .PKT_LEN(PKT_LEN), .IW(IW)) u_emit (
    .clk(clk), .rst_n(rst_n), .lock(lock), .full(full), .err(err),
    .rd_data(rd_data), .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_clr(rd_clr),
    .seq_start(seq_start), .emit_data(emit_data), .emit_ctl(emit_ctl)
  );

  ts_launch #(.DW(DW)) u_launch (
    .clk(clk), .rst_n(rst_n), .clk_pol(clk_pol), .oe_n(oe_n),
    .emit_data(emit_data), .emit_ctl(emit_ctl),
    .out_data(ts_data), .out_ctl(out_ctl)
  );

  assign ts_sop   = out_ctl.sop;
  assign ts_val   = out_ctl.val;
  assign ts_err_n = out_ctl.err_n;

endmodule

// File: rtl/ts_par_out_chk.sv
module ts_par_out_chk #(
  parameter int DW      = 8,
  parameter int PKT_LEN = 188
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic [DW-1:0] ts_data,
  input logic          ts_sop,
  input logic          ts_val,
  input logic          ts_err_n,
  input logic          ovf_flag,
  input logic          drop_evt
);

  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (ts_val) run_len <= ts_sop ? 16'd1 : run_len + 16'd1;
    else             run_len <= '0;
  end

  // R2
  sop_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_sop |-> ts_val);

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 16'(PKT_LEN));

  // R3
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_val |-> (ts_data == '0) && !ts_sop);

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_val && $past(ts_val)) |-> $stable(ts_err_n));

  // R5
  sop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_sop |-> !$past(ts_val));

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> (!ts_val && !ts_sop && ts_err_n && (ts_data == '0)));

  // R10
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_flag) |-> ovf_flag);

endmodule

bind ts_par_out ts_par_out_chk #(.DW(DW), .PKT_LEN(PKT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ts_data(ts_data), .ts_sop(ts_sop),
  .ts_val(ts_val), .ts_err_n(ts_err_n), .ovf_flag(ovf_flag), .drop_evt(drop_evt)
);

// File: tb/ts_par_out_tb.sv
`timescale 1ns/1ps
module ts_par_out_tb;

  localparam int CLK_NS = 10;
  localparam int PKT    = 188;
  localparam int CAPMAX = 8;

  logic       clk, rst_n, lock, clk_pol, oe_n;
  logic [7:0] in_data;
  logic       in_valid, in_sop, in_uncorr;
  logic [7:0] ts_data;
  logic       ts_sop, ts_val, ts_err_n, ovf_flag;

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  ts_par_out #(.DW(8), .PKT_LEN(PKT)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock(lock), .clk_pol(clk_pol), .oe_n(oe_n),
    .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_uncorr(in_uncorr),
    .ts_data(ts_data), .ts_sop(ts_sop), .ts_val(ts_val), .ts_err_n(ts_err_n),
    .ovf_flag(ovf_flag)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'(seed * 37 + i * 3 + 1);
  endfunction

  // Output monitor, sampling 2 ns after each rising edge
  logic [7:0] cap_mem [CAPMAX*PKT];
  bit   cap_errf [CAPMAX];
  int   cap_n, cur_len, gap_run, last_gap;
  bit   in_pkt, cur_err_n, prev_val;
  int   v_gap, v_idle, v_sop, v_err, v_contig;

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      in_pkt = 0; prev_val = 0; gap_run = 0;
    end else begin
      if (ts_val) begin
        if (ts_sop) begin
          if (prev_val) v_gap++;
          last_gap  = gap_run;
          in_pkt    = 1;
          cur_len   = 0;
          cur_err_n = ts_err_n;
          if (cap_n < CAPMAX) cap_errf[cap_n] = !ts_err_n;
        end else begin
          if (!in_pkt) v_sop++;
          if (ts_err_n != cur_err_n) v_err++;
        end
        if (in_pkt) begin
          if (cap_n < CAPMAX) cap_mem[cap_n*PKT + cur_len] = ts_data;
          cur_len++;
          if (cur_len == PKT) begin
            cap_n++;
            in_pkt = 0;
          end
        end
        gap_run = 0;
      end else begin
        if (ts_data != 0 || ts_sop || !ts_err_n) v_idle++;
        if (in_pkt) begin v_contig++; in_pkt = 0; end
        gap_run++;
      end
      prev_val = ts_val;
    end
  end

  task automatic clear_mon();
    cap_n = 0; v_gap = 0; v_idle = 0; v_sop = 0; v_err = 0; v_contig = 0;
  endtask

  task automatic idle_in(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int seed, input int len, input int err_pos);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sop    = (i == 0);
      in_data   = pbyte(seed, i);
      in_uncorr = (i == err_pos);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_data = '0; in_uncorr = 1'b0;
  endtask

  task automatic stray_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(200 + i); in_uncorr = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0; in_data = '0; in_uncorr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic check_pkt(input int slot, input int seed, input bit exp_err,
                           input string req);
    int mism = 0;
    for (int i = 0; i < PKT; i++)
      if (cap_mem[slot*PKT + i] != pbyte(seed, i)) mism++;
    chk(mism == 0, req, "payload mismatches", mism, 0);
    chk(cap_errf[slot] == exp_err, req, "error flag low", int'(cap_errf[slot]), int'(exp_err));
  endtask

  task automatic check_clean(input string req);
    chk(v_contig == 0 && v_sop == 0, req, "broken bursts", v_contig + v_sop, 0);
    chk(v_idle == 0, req, "non-idle gap samples", v_idle, 0);
  endtask

  // Probes which edge moves the data bus during a burst
  task automatic edge_probe(output bit ch_fall, output bit ch_rise);
    logic [7:0] b, c, d, e;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); #2;
      if (ts_val) break;
    end
    #2; b = ts_data;   // rise+4
    #2; c = ts_data;   // rise+6, past falling edge
    #3; d = ts_data;   // rise+9
    #2; e = ts_data;   // rise+11, past next rising edge
    ch_fall = (b != c);
    ch_rise = (d != e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lock = 1'b0; clk_pol = 1'b0; oe_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_data = '0; in_uncorr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(ts_data == 0 && !ts_sop && !ts_val && ts_err_n && !ovf_flag, "R1",
        "outputs in reset", {ts_data, ts_sop, ts_val, ts_err_n, ovf_flag}, 1 << 1);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(3);
    chk(ts_data == 0 && !ts_sop && !ts_val && ts_err_n && !ovf_flag, "R1",
        "outputs after reset", {ts_data, ts_sop, ts_val, ts_err_n, ovf_flag}, 1 << 1);
  endtask

  task automatic t_basic();
    bit s1, s2, f, r;
    lock = 1'b1; clk_pol = 1'b0; oe_n = 1'b0;
    clear_mon();
    send_pkt(1, PKT, -1);
    @(posedge clk); #2; s1 = ts_sop;
    @(posedge clk); #2; s2 = ts_sop;
    chk(!s1, "R6", "sop after first edge", int'(s1), 0);
    chk(s2, "R6", "sop after second edge", int'(s2), 1);
    edge_probe(f, r);
    chk(!f && r, "R7", "rising-launch edges (fall,rise)", {f, r}, 1);
    wait_cyc(250);
    chk(cap_n == 1, "R2", "bursts seen", cap_n, 1);
    check_pkt(0, 1, 0, "R2");
    check_clean("R3");
  endtask

  task automatic t_err();
    clear_mon();
    send_pkt(2, PKT, PKT - 1); idle_in(3);
    send_pkt(3, PKT, 90);      idle_in(3);
    send_pkt(4, PKT, -1);
    wait_cyc(500);
    chk(cap_n == 3, "R4", "bursts seen", cap_n, 3);
    check_pkt(0, 2, 1, "R4");
    check_pkt(1, 3, 1, "R4");
    check_pkt(2, 4, 0, "R4");
    chk(v_err == 0, "R4", "err_n changes in burst", v_err, 0);
    chk(v_gap == 0, "R5", "bursts without gap", v_gap, 0);
    chk(!ovf_flag, "R10", "overflow without drop", int'(ovf_flag), 0);
  endtask

  task automatic t_trunc();
    clear_mon();
    stray_bytes(20);
    send_pkt(5, 60, 10);
    send_pkt(6, PKT, -1);
    stray_bytes(10);
    wait_cyc(400);
    chk(cap_n == 1, "R11", "bursts seen", cap_n, 1);
    check_pkt(0, 6, 0, "R11");
    check_clean("R12");
  endtask

  task automatic t_lock_ovf();
    lock = 1'b0;
    clear_mon();
    send_pkt(7, PKT, -1); idle_in(3);
    send_pkt(8, PKT, 40); idle_in(3);
    send_pkt(9, PKT, -1);
    wait_cyc(50);
    chk(cap_n == 0 && !ts_val, "R9", "bursts while unlocked", cap_n, 0);
    chk(ovf_flag, "R10", "overflow flag", int'(ovf_flag), 1);
    @(negedge clk); lock = 1'b1;
    wait_cyc(500);
    chk(cap_n == 2, "R10", "bursts after lock", cap_n, 2);
    check_pkt(0, 7, 0, "R9");
    check_pkt(1, 8, 1, "R10");
    chk(last_gap == 1, "R5", "gap before stored packet", last_gap, 1);
    chk(ovf_flag, "R10", "overflow still set", int'(ovf_flag), 1);
  endtask

  task automatic t_oe();
    int bad = 0;
    @(negedge clk); oe_n = 1'b1;
    clear_mon();
    fork
      send_pkt(10, PKT, 5);
      for (int k = 0; k < 400; k++) begin
        @(posedge clk); #2;
        if (k > 1 && (ts_val || ts_sop || ts_data != 0 || !ts_err_n)) bad++;
      end
    join
    chk(bad == 0, "R8", "non-idle samples while disabled", bad, 0);
    @(negedge clk); oe_n = 1'b0;
    wait_cyc(300);
    chk(cap_n == 0, "R8", "bursts after enable", cap_n, 0);
    send_pkt(11, PKT, -1);
    wait_cyc(250);
    chk(cap_n == 1, "R8", "bursts after resume", cap_n, 1);
    check_pkt(0, 11, 0, "R8");
  endtask

  task automatic t_pol();
    bit f, r;
    @(negedge clk); clk_pol = 1'b1;
    clear_mon();
    send_pkt(12, PKT, -1);
    edge_probe(f, r);
    chk(f && !r, "R7", "falling-launch edges (fall,rise)", {f, r}, 2);
    wait_cyc(250);
    chk(cap_n == 1, "R7", "bursts seen", cap_n, 1);
    check_pkt(0, 12, 0, "R7");
    check_clean("R7");
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_err();
    t_trunc();
    t_lock_ovf();
    t_oe();
    t_pol();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule